// File: doc/BRIEF.md
# Two-Stage SCL Rate Generator

This block derives the serial-clock timing of an I2C master from a fast system clock. Two programmable prescalers are chained. The first divides the system clock by a small factor. The second divides the first stage's enable pulses by a larger factor. Each output of the second stage is one "tick". A fixed sequencer then spends 22 ticks on every SCL period, so the bit rate is f_clk / (22 × (A+1) × (B+1)), where A and B are the two programmed fields.

The bus state machine uses a level output for the SCL line and four single-cycle strobes: the falling edge of SCL, the rising edge of SCL, a point in the middle of the low phase where SDA may change, and a point in the middle of the high phase where SDA is sampled. The transfer engine can ask for a pause through a hold input. While SCL is low the sequencer then freezes, and SCL stays low until the hold is released. Divider fields that change while a period is running are held back and take effect at the next period boundary.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, SCL is low, all four strobes are low, and the divider fields in use are A=3 and B=63. The first SCL falling strobe therefore arrives 22×4×64 = 5632 clock cycles after reset is released, whatever the input fields hold.
- R2: A tick lasts T = (A+1)×(B+1) clock cycles. An SCL period is 22 ticks, so consecutive falling strobes are 22×T cycles apart.
- R3: Field A is 2 bits wide and selects a first-stage divisor of A+1 (1 to 4). Field B is 6 bits wide and selects a second-stage divisor of B+1 (1 to 64). A field value of 0 means divide by one.
- R4: SCL is low for ticks 0 to 10 of a period and high for ticks 11 to 21. The fall strobe is high in the first cycle of SCL low. The rise strobe is high in the first cycle of SCL high, which is 11×T cycles after the fall strobe.
- R5: The data-change strobe comes 5×T cycles after the fall strobe. The sample strobe comes 16×T cycles after the fall strobe.
- R6: A field value presented to the inputs is used only from the next period boundary, which is the next fall strobe. The period that is running when the value changes keeps its old length.
- R7: While hold is high and SCL is low, the tick sequence does not advance and SCL stays low. Every tick that falls inside the hold adds T cycles to the strobes that follow.
- R8: Hold has no effect while SCL is high. The period keeps its length, but it freezes at the next low phase if hold is still high.
- R9: Each strobe is one cycle wide. At most one strobe is high in any cycle, and each period has exactly one data-change, one rise, one sample and one fall strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_a_i | input | 2 | First-stage divisor minus one |
| div_b_i | input | 6 | Second-stage divisor minus one |
| hold_i | input | 1 | Pause request from the transfer engine |
| scl_o | output | 1 | SCL level (1 = released high) |
| scl_rise_o | output | 1 | Strobe: first cycle of SCL high |
| scl_fall_o | output | 1 | Strobe: first cycle of SCL low |
| drive_o | output | 1 | Strobe: SDA may change (mid-low) |
| sample_o | output | 1 | Strobe: SDA sample point (mid-high) |

## Verification
Every strobe is registered together with the SCL level. It therefore appears one cycle after the clock edge at which the last tick of the wait completes, and this places the data-change, rise, sample and next fall strobes exactly 5T, 11T, 16T and 22T cycles after a fall strobe (plus any frozen ticks). The bench counts clock edges from the release of reset and samples on the falling clock edge. For each period a queued entry gives the expected T and the hold extension, and each strobe's offset from the last fall strobe is compared with that entry. Field changes are applied in the middle of a period and the new length is expected only in the next period. Holds are placed right after a fall strobe or a rise strobe so that the number of frozen ticks is known exactly.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    // Ticks per SCL period and position of the phase events inside it
    localparam int unsigned PHASES    = 22;
    localparam int unsigned HALF      = PHASES / 2;
    localparam int unsigned DRIVE_PH  = HALF / 2;
    localparam int unsigned SAMPLE_PH = HALF + HALF / 2;
    localparam int unsigned PH_W      = $clog2(PHASES);

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        phase_t phase;
        logic   scl;
        logic   rise;
        logic   fall;
        logic   drive;
        logic   sample;
    } seq_state_t;

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] lim_i,
    output logic         pulse_o
);

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_lim;

    always_comb begin
        at_lim  = (cnt_q == lim_i);
        pulse_o = en_i && at_lim;
        cnt_d   = cnt_q;
        if (en_i) begin
            cnt_d = at_lim ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the counter never passes the programmed divisor minus one
    p_cnt_le_lim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_i);

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    output logic wrap_o,
    output logic scl_o,
    output logic rise_o,
    output logic fall_o,
    output logic drive_o,
    output logic sample_o
);

    localparam phase_t LAST_PH = phase_t'(PHASES - 1);
    localparam phase_t HALF_PH = phase_t'(HALF);
    localparam phase_t DRV_PH  = phase_t'(DRIVE_PH);
    localparam phase_t SMP_PH  = phase_t'(SAMPLE_PH);

    seq_state_t s_d, s_q;
    logic       frozen;
    logic       adv;

    always_comb begin
        frozen = hold_i && (s_q.phase < HALF_PH);
        adv    = tick_i && !frozen;
        wrap_o = adv && (s_q.phase == LAST_PH);

        s_d        = s_q;
        s_d.rise   = 1'b0;
        s_d.fall   = 1'b0;
        s_d.drive  = 1'b0;
        s_d.sample = 1'b0;
        if (adv) begin
            s_d.phase  = wrap_o ? '0 : s_q.phase + phase_t'(1);
            s_d.scl    = (s_d.phase >= HALF_PH);
            s_d.fall   = (s_d.phase == '0);
            s_d.rise   = (s_d.phase == HALF_PH);
            s_d.drive  = (s_d.phase == DRV_PH);
            s_d.sample = (s_d.phase == SMP_PH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scl_o    = s_q.scl;
    assign rise_o   = s_q.rise;
    assign fall_o   = s_q.fall;
    assign drive_o  = s_q.drive;
    assign sample_o = s_q.sample;

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase <= LAST_PH);

    p_fall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fall |-> !s_q.scl);

    p_rise_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rise |-> s_q.scl);

    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !s_q.scl) |=> ($stable(s_q.phase) && !s_q.scl));

    p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_q.rise, s_q.fall, s_q.drive, s_q.sample}));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int unsigned A_W = 2,
    parameter int unsigned B_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] div_a_i,
    input  logic [B_W-1:0] div_b_i,
    input  logic           hold_i,
    output logic           scl_o,
    output logic           scl_rise_o,
    output logic           scl_fall_o,
    output logic           drive_o,
    output logic           sample_o
);

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } div_t;

    // Slowest setting: every field bit set
    localparam div_t DIV_RST = '{a: '1, b: '1};

    div_t div_d, div_q;
    logic s1_pulse;
    logic tick;
    logic wrap;

    // Fields in use change only at a period boundary
    always_comb begin
        div_d = div_q;
        if (wrap) begin
            div_d.a = div_a_i;
            div_d.b = div_b_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= DIV_RST;
        else        div_q <= div_d;
    end

    scl_prescale #(.W(A_W)) u_stage_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (1'b1),
        .lim_i   (div_q.a),
        .pulse_o (s1_pulse)
    );

    scl_prescale #(.W(B_W)) u_stage_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (s1_pulse),
        .lim_i   (div_q.b),
        .pulse_o (tick)
    );

    scl_phase_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .hold_i   (hold_i),
        .wrap_o   (wrap),
        .scl_o    (scl_o),
        .rise_o   (scl_rise_o),
        .fall_o   (scl_fall_o),
        .drive_o  (drive_o),
        .sample_o (sample_o)
    );

    p_div_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(div_q));

    p_fall_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> scl_fall_o);

endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;

    typedef struct {
        int t;
        int ext;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_a = 2'd0;
    logic [5:0] div_b = 6'd1;
    logic       hold = 1'b0;
    logic       scl, rise, fall, drv, smp;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    scl_rate_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_a_i    (div_a),
        .div_b_i    (div_b),
        .hold_i     (hold),
        .scl_o      (scl),
        .scl_rise_o (rise),
        .scl_fall_o (fall),
        .drive_o    (drive_o_w),
        .sample_o   (sample_o_w)
    );
    logic drive_o_w, sample_o_w;
    assign drv = drive_o_w;
    assign smp = sample_o_w;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int t, input int ext);
        item_t it;
        it.t = t;
        it.ext = ext;
        exp_q.push_back(it);
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (!fall) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: measures strobe offsets from the last fall strobe
    initial begin
        item_t cur;
        int    start;
        int    off;
        bit    active;
        int    n_drv, n_rise, n_smp;
        wait (rst_n);
        cur = exp_q.pop_front();
        start = 0;
        active = 1'b1;
        n_drv = 0; n_rise = 0; n_smp = 0;
        forever begin
            @(negedge clk);
            if (active) begin
                off = cyc - start;
                // R9: never two strobes in one cycle
                chk($countones({rise, fall, drv, smp}) <= 1, "R9 strobes per cycle",
                    $countones({rise, fall, drv, smp}), 1);
                if (drv) begin
                    n_drv++;
                    chk(off == 5 * cur.t + cur.ext, "R5 drive offset", off, 5 * cur.t + cur.ext);
                end
                if (rise) begin
                    n_rise++;
                    chk(off == 11 * cur.t + cur.ext, "R4 rise offset", off, 11 * cur.t + cur.ext);
                    chk(scl == 1'b1, "R4 scl high at rise", scl, 1);
                end
                if (smp) begin
                    n_smp++;
                    chk(off == 16 * cur.t + cur.ext, "R5 sample offset", off, 16 * cur.t + cur.ext);
                end
                if (fall) begin
                    // R2 / R6: period length from the queued entry
                    chk(off == 22 * cur.t + cur.ext, "R2 period length", off, 22 * cur.t + cur.ext);
                    chk(scl == 1'b0, "R4 scl low at fall", scl, 0);
                    chk(n_drv == 1 && n_rise == 1 && n_smp == 1, "R9 one of each strobe",
                        n_drv + n_rise + n_smp, 3);
                    n_drv = 0; n_rise = 0; n_smp = 0;
                    start = cyc;
                    if (exp_q.size() > 0) cur = exp_q.pop_front();
                    else                  active = 1'b0;
                end
            end
        end
    end

    // Driver
    initial begin
        // R1: first period at the reset defaults (4 x 64), inputs ignored
        push(256, 0);
        push(2, 0);     // R3: A=0 -> /1, B=1 -> /2
        push(2, 20);    // R7: hold in low half, 10 ticks frozen
        push(2, 0);     // R8: hold in high half, no effect
        push(2, 0);     // R6: fields change mid-period, old length kept
        push(6, 0);     // A=1,B=2
        push(6, 0);
        push(4, 0);     // A=3,B=0
        push(18, 0);    // A=2,B=5
        push(1, 0);     // A=0,B=0: divide by one in both stages
        push(1, 0);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(scl == 1'b0, "R1 scl low in reset", scl, 0);
        chk({rise, fall, drv, smp} == 4'b0, "R1 strobes low in reset", {rise, fall, drv, smp}, 0);
        rst_n = 1'b1;

        wait_fall();
        chk(cyc == 5632, "R1 first fall at default rate", cyc, 5632);

        wait_fall();   // start of the held period
        hold = 1'b1;
        repeat (20) begin
            @(negedge clk);
            chk(scl == 1'b0 && fall == 1'b0 && drv == 1'b0, "R7 scl held low", scl, 0);
        end
        hold = 1'b0;

        wait_fall();   // start of the high-half hold period
        @(negedge clk);
        while (!rise) @(negedge clk);
        hold = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(scl == 1'b1, "R8 scl stays high under hold", scl, 1);
        end
        hold = 1'b0;

        wait_fall();
        repeat (10) @(negedge clk);
        div_a = 2'd1;
        div_b = 6'd2;

        wait_fall();
        wait_fall();
        repeat (5) @(negedge clk);
        div_a = 2'd3;
        div_b = 6'd0;

        wait_fall();
        div_a = 2'd2;
        div_b = 6'd5;

        wait_fall();
        div_a = 2'd0;
        div_b = 6'd0;

        wait_fall();
        wait_fall();
        wait_fall();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all periods observed", exp_q.size(), 0);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        finish_run();
    end

endmodule